// File: doc/BRIEF.md
# Queue Converter Interrupt Flag Controller

This block holds the event flags and drives the interrupt requests for a converter that runs two command queues. Each queue reports two kinds of events through single-cycle strobes from the conversion sequencer. A completion strobe marks the result write for the final command word of the queue. A pause strobe marks the result write for a command word whose pause marker is set. Each event sets a sticky flag. When the enable bit for that source is also set, the flag drives a dedicated interrupt request line. Each of the four sources therefore has its own vector level.

Software observes the flags through a small synchronous register port. To clear a flag, software must first read the status register while that flag shows 1, and then write 0 to that bit. The clear is race-safe. If a new event for a flag arrives between that read and the clearing write, the write has no effect on that flag, so the event is not lost. Polling works in the same way whether or not the interrupts are enabled.

Top module: `qflag_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all flags, all enable bits and all clear-permission state. After reset, every interrupt output is 0 and read data is 0.
- R2: A strobe on the completion input of queue 1 sets status bit 0. A strobe on the completion input of queue 2 sets status bit 2.
- R3: A strobe on the pause input of queue 1 sets status bit 1. A strobe on the pause input of queue 2 sets status bit 3.
- R4: Each source drives its own request output. That output is 1 exactly while its flag and its enable bit are both 1, so it stays high until the flag clears or the enable is removed.
- R5: A write to the status register (address 0) with a 0 in a bit clears that flag, provided an earlier status read returned the bit as 1. Writing 1 to a bit leaves it unchanged.
- R6: Writing 0 to a flag that has not been read as 1 since its last set event leaves the flag set.
- R7: If a set event for a flag occurs after the status read and before the clearing write, the flag stays set after that write.
- R8: When a set event and a qualifying clearing write land in the same cycle, the flag ends up set.
- R9: The enable register at address 4 uses the same bit order as the status register. Bits 31:4 are ignored on write and read back as 0.
- R10: A read returns its data on busRdata one cycle after busRd, and the data holds until the next read. A status read shows the flags whatever the enables are.
- R11: Reads at any address other than 0 and 4 return 0. Writes at such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 4 | Register byte address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| q1DoneStb | input | 1 | Queue 1 last-word result write |
| q1PauseStb | input | 1 | Queue 1 paused-word result write |
| q2DoneStb | input | 1 | Queue 2 last-word result write |
| q2PauseStb | input | 1 | Queue 2 paused-word result write |
| irqQ1Done | output | 1 | Queue 1 completion request |
| irqQ1Pause | output | 1 | Queue 1 pause request |
| irqQ2Done | output | 1 | Queue 2 completion request |
| irqQ2Pause | output | 1 | Queue 2 pause request |

## Verification
The properties assume that the event strobes and the bus strobes are clean single-cycle levels sampled on the rising edge. They also assume that no request line is expected to fall in a cycle that follows neither a bus write nor a flag change. The stimulus never asserts busRd and busWr in the same cycle, because the bus is a single-cycle port. It issues addresses from the word-aligned set 0, 4, 8 and 12, and it raises event strobes at random, including in the cycles between a status read and a clearing write. That last point deliberately exercises the race rules.

// File: rtl/qflag_pkg.sv
package qflag_pkg;
  localparam int NUM_SRC = 4;

  // bit positions shared by the status and enable registers
  localparam int SRC_Q1_DONE  = 0;
  localparam int SRC_Q1_PAUSE = 1;
  localparam int SRC_Q2_DONE  = 2;
  localparam int SRC_Q2_PAUSE = 3;

  typedef logic [NUM_SRC-1:0] srcVec_t;

  // decoded bus strobes from control to datapath
  typedef struct packed {
    logic rdStatus;
    logic rdEnable;
    logic rdOther;
    logic wrStatus;
    logic wrEnable;
  } busCmd_t;
endpackage

// File: rtl/qflag_ctrl.sv
module qflag_ctrl
  import qflag_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STATUS_OFS = 0,
  parameter int ENABLE_OFS = 4
) (
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              q1DoneStb,
  input  logic              q1PauseStb,
  input  logic              q2DoneStb,
  input  logic              q2PauseStb,
  output busCmd_t           cmd,
  output srcVec_t           setVec
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(ENABLE_OFS);

  logic hitStatus;
  logic hitEnable;

  always_comb begin
    hitStatus = (busAddr == STATUS_ADDR);
    hitEnable = (busAddr == ENABLE_ADDR);
    cmd.rdStatus = busRd && hitStatus;
    cmd.rdEnable = busRd && hitEnable;
    cmd.rdOther  = busRd && !hitStatus && !hitEnable;
    cmd.wrStatus = busWr && hitStatus;
    cmd.wrEnable = busWr && hitEnable;
  end

  always_comb begin
    setVec               = '0;
    setVec[SRC_Q1_DONE]  = q1DoneStb;
    setVec[SRC_Q1_PAUSE] = q1PauseStb;
    setVec[SRC_Q2_DONE]  = q2DoneStb;
    setVec[SRC_Q2_PAUSE] = q2PauseStb;
  end
endmodule

// File: rtl/qflag_datapath.sv
module qflag_datapath
  import qflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  busCmd_t           cmd,
  input  srcVec_t           setVec,
  input  srcVec_t           wrBits,
  output srcVec_t           flagVec,
  output srcVec_t           enVec,
  output srcVec_t           irqVec,
  output logic [DATA_W-1:0] rdData
);
  srcVec_t armVec;

  // one flag / clear-permission pair per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic clrOk;
    assign clrOk = cmd.wrStatus && !wrBits[i] && armVec[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        flagVec[i] <= 1'b0;
      end else if (setVec[i]) begin
        flagVec[i] <= 1'b1;          // set beats clear
      end else if (clrOk) begin
        flagVec[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        armVec[i] <= 1'b0;
      end else if (setVec[i]) begin
        armVec[i] <= 1'b0;           // new event needs a fresh read
      end else if (cmd.wrStatus && !wrBits[i]) begin
        armVec[i] <= 1'b0;
      end else if (cmd.rdStatus && flagVec[i]) begin
        armVec[i] <= 1'b1;
      end
    end

    assign irqVec[i] = flagVec[i] & enVec[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enVec <= '0;
    end else if (cmd.wrEnable) begin
      enVec <= wrBits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (cmd.rdStatus) begin
      rdData <= DATA_W'(flagVec);
    end else if (cmd.rdEnable) begin
      rdData <= DATA_W'(enVec);
    end else if (cmd.rdOther) begin
      rdData <= '0;
    end
  end
endmodule

// File: rtl/qflag_irq_ctrl.sv
module qflag_irq_ctrl
  import qflag_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              q1DoneStb,
  input  logic              q1PauseStb,
  input  logic              q2DoneStb,
  input  logic              q2PauseStb,
  output logic              irqQ1Done,
  output logic              irqQ1Pause,
  output logic              irqQ2Done,
  output logic              irqQ2Pause
);
  busCmd_t cmd;
  srcVec_t setVec;
  srcVec_t flagVec;
  srcVec_t enVec;
  srcVec_t irqVec;
  logic    unusedWdataHi;

  assign unusedWdataHi = ^busWdata[DATA_W-1:NUM_SRC];

  qflag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busRd      (busRd),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .q1DoneStb  (q1DoneStb),
    .q1PauseStb (q1PauseStb),
    .q2DoneStb  (q2DoneStb),
    .q2PauseStb (q2PauseStb),
    .cmd        (cmd),
    .setVec     (setVec)
  );

  qflag_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .setVec  (setVec),
    .wrBits  (busWdata[NUM_SRC-1:0]),
    .flagVec (flagVec),
    .enVec   (enVec),
    .irqVec  (irqVec),
    .rdData  (busRdata)
  );

  assign irqQ1Done  = irqVec[SRC_Q1_DONE];
  assign irqQ1Pause = irqVec[SRC_Q1_PAUSE];
  assign irqQ2Done  = irqVec[SRC_Q2_DONE];
  assign irqQ2Pause = irqVec[SRC_Q2_PAUSE];
endmodule

// File: rtl/qflag_irq_ctrl_chk.sv
module qflag_irq_ctrl_chk
  import qflag_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input srcVec_t           setVec,
  input srcVec_t           flagVec,
  input srcVec_t           enVec,
  input srcVec_t           irqVec
);
  localparam srcVec_t DONE_MASK  = srcVec_t'((1 << SRC_Q1_DONE) | (1 << SRC_Q2_DONE));
  localparam srcVec_t PAUSE_MASK = srcVec_t'((1 << SRC_Q1_PAUSE) | (1 << SRC_Q2_PAUSE));

  logic wrStat;
  logic wrEn;
  logic rdOther;
  assign wrStat  = busWr && (busAddr == ADDR_W'(0));
  assign wrEn    = busWr && (busAddr == ADDR_W'(4));
  assign rdOther = busRd && (busAddr != ADDR_W'(0)) && (busAddr != ADDR_W'(4));

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    (|(setVec & DONE_MASK)) |=> ((flagVec & $past(setVec & DONE_MASK)) == $past(setVec & DONE_MASK))); // R2
  AST_PAUSE_SETS: assert property (@(posedge clk) disable iff (rst)
    (|(setVec & PAUSE_MASK)) |=> ((flagVec & $past(setVec & PAUSE_MASK)) == $past(setVec & PAUSE_MASK))); // R3
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !busWr |=> ((irqVec & $past(irqVec)) == $past(irqVec))); // R4
  AST_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|($past(flagVec) & ~flagVec)) |-> $past(wrStat)); // R6
  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    wrStat |=> ((flagVec & $past(flagVec & busWdata[NUM_SRC-1:0])) == $past(flagVec & busWdata[NUM_SRC-1:0]))); // R5
  AST_ENABLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(enVec)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdOther |=> (busRdata == '0)); // R11
endmodule

bind qflag_irq_ctrl qflag_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busAddr  (busAddr),
  .busRd    (busRd),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .setVec   (setVec),
  .flagVec  (flagVec),
  .enVec    (enVec),
  .irqVec   (irqVec)
);

// File: tb/qflag_irq_ctrl_test.sv
`timescale 1ns/1ps
module qflag_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        q1DoneStb = 1'b0, q1PauseStb = 1'b0, q2DoneStb = 1'b0, q2PauseStb = 1'b0;
  logic        irqQ1Done, irqQ1Pause, irqQ2Done, irqQ2Pause;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // bench reference state
  logic [3:0]  mFlag = '0, mEn = '0, mArm = '0;
  logic [31:0] mRd = '0;

  always #10 clk = ~clk;

  qflag_irq_ctrl uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata),
    .q1DoneStb(q1DoneStb), .q1PauseStb(q1PauseStb),
    .q2DoneStb(q2DoneStb), .q2PauseStb(q2PauseStb),
    .irqQ1Done(irqQ1Done), .irqQ1Pause(irqQ1Pause),
    .irqQ2Done(irqQ2Done), .irqQ2Pause(irqQ2Pause));

  function automatic logic [3:0] irqNow();
    return {irqQ2Pause, irqQ2Done, irqQ1Pause, irqQ1Done};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference step built from the requirements
  task automatic modelStep(input logic [3:0] a, input logic r, input logic w,
                           input logic [31:0] d, input logic [3:0] st);
    logic [3:0] nf, na;
    logic rdS, wrS;
    rdS = r && a == 4'd0;
    wrS = w && a == 4'd0;
    for (int i = 0; i < 4; i++) begin
      nf[i] = st[i] | (mFlag[i] & ~(wrS & ~d[i] & mArm[i]));
      if (st[i]) na[i] = 1'b0;
      else if (wrS && !d[i]) na[i] = 1'b0;
      else if (rdS && mFlag[i]) na[i] = 1'b1;
      else na[i] = mArm[i];
    end
    if (r) mRd = (a == 4'd0) ? {28'd0, mFlag} : (a == 4'd4) ? {28'd0, mEn} : 32'd0;
    if (w && a == 4'd4) mEn = d[3:0];
    mFlag = nf;
    mArm = na;
  endtask

  // one clock: drive after negedge, compare at next negedge
  task automatic doCycle(input logic [3:0] a, input logic r, input logic w,
                         input logic [31:0] d, input logic [3:0] st);
    busAddr = a; busRd = r; busWr = w; busWdata = d;
    {q2PauseStb, q2DoneStb, q1PauseStb, q1DoneStb} = st;
    modelStep(a, r, w, d, st);
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
    {q2PauseStb, q2DoneStb, q1PauseStb, q1DoneStb} = 4'd0;
    check(irqNow() == (mFlag & mEn), "R4 request outputs", {28'd0, irqNow()}, {28'd0, mFlag & mEn});
    check(busRdata == mRd, "R10 read data", busRdata, mRd);
  endtask

  task automatic readReg(input logic [3:0] a);
    doCycle(a, 1'b1, 1'b0, 32'd0, 4'd0);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d, input logic [3:0] st);
    doCycle(a, 1'b0, 1'b1, d, st);
  endtask

  task automatic pulse(input logic [3:0] st);
    doCycle(4'd0, 1'b0, 1'b0, 32'd0, st);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1357_2468));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    check(irqNow() == 4'd0, "R1 irq after reset", {28'd0, irqNow()}, 32'd0);
    check(busRdata == 32'd0, "R1 rdata after reset", busRdata, 32'd0);
    readReg(4'd0); check(busRdata == 32'd0, "R1 status after reset", busRdata, 32'd0);
    readReg(4'd4); check(busRdata == 32'd0, "R1 enable after reset", busRdata, 32'd0);
    // R2
    pulse(4'b0001); readReg(4'd0); check(busRdata == 32'h1, "R2 q1 done", busRdata, 32'h1);
    pulse(4'b0100); readReg(4'd0); check(busRdata == 32'h5, "R2 q2 done", busRdata, 32'h5);
    // R3
    pulse(4'b1010); readReg(4'd0); check(busRdata == 32'hF, "R3 pause bits", busRdata, 32'hF);
    check(irqNow() == 4'd0, "R10 flags polled with enables off", {28'd0, irqNow()}, 32'd0);
    // R9
    writeReg(4'd4, 32'hFFFF_FFF5, 4'd0); readReg(4'd4);
    check(busRdata == 32'h5, "R9 enable readback", busRdata, 32'h5);
    check(irqNow() == 4'h5, "R4 enabled requests", {28'd0, irqNow()}, 32'h5);
    // R5: flags read as F above; clear bits 0 and 2
    readReg(4'd0);
    writeReg(4'd0, 32'h0000_000A, 4'd0); readReg(4'd0);
    check(busRdata == 32'hA, "R5 read-then-write clear", busRdata, 32'hA);
    check(irqNow() == 4'h0, "R4 requests drop on clear", {28'd0, irqNow()}, 32'h0);
    // R6: new events disarm bits 1 and 3, then write 0 without read
    pulse(4'b1010);
    writeReg(4'd0, 32'h0, 4'd0); readReg(4'd0);
    check(busRdata == 32'hA, "R6 clear without read ignored", busRdata, 32'hA);
    // R7: read arms, event on bit 1 intervenes, write 0
    pulse(4'b0010);
    writeReg(4'd0, 32'h0, 4'd0); readReg(4'd0);
    check(busRdata == 32'h2, "R7 intervening event keeps flag", busRdata, 32'h2);
    // R8: read arms bit 1, write 0 coincides with event on bit 1
    writeReg(4'd0, 32'h0, 4'b0010); readReg(4'd0);
    check(busRdata == 32'h2, "R8 set wins over clear", busRdata, 32'h2);
    writeReg(4'd0, 32'h0, 4'd0); readReg(4'd0);
    check(busRdata == 32'h0, "R5 final clear", busRdata, 32'h0);
    // R11
    writeReg(4'd8, 32'h0, 4'd0); writeReg(4'd12, 32'hF, 4'd0);
    readReg(4'd4); check(busRdata == 32'h5, "R11 enables untouched", busRdata, 32'h5);
    readReg(4'd8); check(busRdata == 32'h0, "R11 unmapped read", busRdata, 32'h0);
    // R4 enable removal
    pulse(4'b0001);
    check(irqQ1Done == 1'b1, "R4 q1 done request", {31'd0, irqQ1Done}, 32'h1);
    writeReg(4'd4, 32'h0, 4'd0);
    check(irqQ1Done == 1'b0, "R4 enable removed", {31'd0, irqQ1Done}, 32'h0);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [3:0] st;
      logic [31:0] d;
      op = int'($urandom % 10);
      for (int i = 0; i < 4; i++) st[i] = ($urandom % 6) == 0;
      d = $urandom;
      if ($urandom % 2 == 0) d[3:0] = d[3:0] & 4'($urandom);
      case (op)
        0, 1, 2: doCycle(4'd0, 1'b1, 1'b0, 32'd0, st);
        3:       doCycle(4'd4, 1'b1, 1'b0, 32'd0, st);
        4, 5:    doCycle(4'd0, 1'b0, 1'b1, d, st);
        6:       doCycle(4'd4, 1'b0, 1'b1, d, st);
        7:       doCycle(4'(($urandom % 2) * 4 + 8), ($urandom % 2) == 0, 1'b0, 32'd0, st);
        8:       doCycle(4'(($urandom % 2) * 4 + 8), 1'b0, 1'b1, d, st);
        default: doCycle(4'd0, 1'b0, 1'b0, 32'd0, st);
      endcase
    end
    summary();
  end
endmodule